// File: doc/BRIEF.md
# Battery Monitor Sleep Controller

This block decides when a battery monitoring controller may drop into its low-power sleep mode and what it does while asleep. It watches the signed current samples that the measurement path delivers, the raw levels of the two serial bus lines, and a configuration bit that can forbid sleep. Sleep is entered only when the current is small in both directions, the bus has been idle for a qualification window, and sleep is allowed.

While asleep, two independent timers driven by a free-running millisecond tick issue single-cycle request pulses. One timer asks for a voltage/temperature measurement together with a self-discharge adjustment. The other asks for a current measurement. The controller returns to full mode on any bus activity, on a current sample above the threshold, or when sleep is disabled. Bus line inputs are synchronized before use. Only their levels and edges are observed; no protocol decoding is done.

Top module: `bat_sleep_ctrl`

## Requirements
- R1: Out of reset the mode is full. Sleep (`sleep_mode`=1) is entered only when all of these hold together: the most recent valid current sample had a magnitude strictly below `cur_thresh`; both bus lines have been low (after synchronization) for `QUAL_MS` counted millisecond ticks; `cfg_sleep_dis` is 0; and no over-threshold sample arrives in that cycle.
- R2: A high level on either synchronized bus line clears the idle qualification count to zero, so a short glitch restarts the full window.
- R3: In sleep, `vt_meas_req` and `self_dis_req` pulse together on every `sleep_period`-th millisecond tick. A period of 0 produces no pulses. One millisecond tick is `TICK_DIV` clock cycles.
- R4: In sleep, `cur_meas_req` pulses on every `icheck_period`-th millisecond tick, independently of the other timer. A period of 0 produces no pulses.
- R5: Both wake timers restart from zero on every sleep entry and are held cleared in full mode. When both expire on the same tick, all three requests pulse in that same cycle.
- R6: A valid sample whose magnitude is greater than `cur_thresh` returns the block to full mode on the next clock edge. The sample is two's complement, so negative values count by magnitude. A magnitude equal to the threshold neither wakes the block nor qualifies it for sleep.
- R7: A rising edge, or a high level, on either bus line returns the block to full mode.
- R8: While `cfg_sleep_dis` is 1, sleep is never entered. Setting the bit while asleep returns the block to full mode on the next clock edge.
- R9: Each bus line passes through a two-flop synchronizer. A bus line that rises before clock edge k changes the mode at edge k+2, as seen after the third edge counting k.
- R10: Every request output is a single-cycle pulse and is asserted only in sleep. The mode and all requests change only on clock edges, and all are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_sample | input | CUR_W | Signed current sample |
| cur_valid | input | 1 | Strobe marking `cur_sample` valid |
| bus_clk_line | input | 1 | Raw level of the bus clock line |
| bus_dat_line | input | 1 | Raw level of the bus data line |
| cfg_sleep_dis | input | 1 | 1 forbids sleep |
| cur_thresh | input | CUR_W | Unsigned current magnitude threshold |
| sleep_period | input | TW | Voltage/temperature wake period in ms ticks |
| icheck_period | input | TW | Current-check wake period in ms ticks |
| sleep_mode | output | 1 | 1 while in sleep mode |
| vt_meas_req | output | 1 | Voltage/temperature measurement request pulse |
| self_dis_req | output | 1 | Self-discharge adjustment request pulse |
| cur_meas_req | output | 1 | Current measurement request pulse |

## Verification
The bench builds the block with `TICK_DIV`=4, `QUAL_MS`=5, `CUR_W`=12 and `TW`=8. A millisecond is then four clocks and the idle window is twenty, so many entry and exit cycles fit into a short run. Wake periods of 2, 3 and 6 ticks make the two timers both run freely and land on common ticks. The short window also makes it cheap to place a glitch at a point where the count without a restart would already have qualified.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic {
        MODE_FULL  = 1'b0,
        MODE_SLEEP = 1'b1
    } pmode_t;

    // Per-line observation after synchronization
    typedef struct packed {
        logic level;
        logic rise;
    } line_obs_t;

    // Request bundle produced while asleep
    typedef struct packed {
        logic vt;
        logic sd;
        logic cur;
    } wake_req_t;

    // Number of bus lines observed
    localparam int unsigned BUS_LINES = 2;

endpackage

// File: rtl/bsc_bus_sync.sv
module bsc_bus_sync
    import bsc_pkg::*;
#(
    parameter int unsigned N_LINES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  line_raw,
    output line_obs_t [N_LINES-1:0] obs
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= line_raw[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        always_comb begin
            obs[g].level = sync_q;
            obs[g].rise  = sync_q & ~prev_q;
        end
    end

endmodule

// File: rtl/bsc_tick_gen.sv
module bsc_tick_gen #(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int unsigned CW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] pre_q;
    logic          wrap;

    assign wrap = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick  <= wrap;
            pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
    end

    // A tick never lasts two cycles when the divider is at least 2
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R10

endmodule

// File: rtl/bsc_wake_timer.sv
module bsc_wake_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          tick,
    input  logic [TW-1:0] period,
    output logic          req
);

    logic [TW-1:0] cnt_q;
    logic          hit;

    assign hit = active && tick && (period != '0) && (cnt_q == period - 1'b1);
    assign req = hit;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    AST_REQ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        req |-> active); // R10

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req |=> !req); // R10

    AST_PERIOD_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |-> !req); // R3

endmodule

// File: rtl/bat_sleep_ctrl.sv
module bat_sleep_ctrl
    import bsc_pkg::*;
#(
    parameter int unsigned CUR_W    = 16,
    parameter int unsigned TW       = 16,
    parameter int unsigned TICK_DIV = 1000,
    parameter int unsigned QUAL_MS  = 2000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [CUR_W-1:0] cur_sample,
    input  logic                    cur_valid,
    input  logic                    bus_clk_line,
    input  logic                    bus_dat_line,
    input  logic                    cfg_sleep_dis,
    input  logic [CUR_W-1:0]        cur_thresh,
    input  logic [TW-1:0]           sleep_period,
    input  logic [TW-1:0]           icheck_period,
    output logic                    sleep_mode,
    output logic                    vt_meas_req,
    output logic                    self_dis_req,
    output logic                    cur_meas_req
);

    localparam int unsigned QW = $clog2(QUAL_MS + 1);
    localparam logic [QW-1:0] QUAL_FULL = QW'(QUAL_MS);

    // ---------------- bus line observation ----------------
    line_obs_t [BUS_LINES-1:0] obs;
    logic                      bus_high;
    logic                      bus_rise;

    bsc_bus_sync #(.N_LINES(BUS_LINES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_raw ({bus_dat_line, bus_clk_line}),
        .obs      (obs)
    );

    always_comb begin
        bus_high = 1'b0;
        bus_rise = 1'b0;
        for (int i = 0; i < int'(BUS_LINES); i++) begin
            bus_high = bus_high | obs[i].level;
            bus_rise = bus_rise | obs[i].rise;
        end
    end

    // ---------------- millisecond tick ----------------
    logic ms_tick;

    bsc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (ms_tick)
    );

    // ---------------- current magnitude ----------------
    logic [CUR_W-1:0] cur_raw;
    logic [CUR_W-1:0] cur_mag;
    logic             cur_over;
    logic             cur_low_q;

    assign cur_raw  = cur_sample;
    assign cur_mag  = cur_raw[CUR_W-1] ? (~cur_raw + 1'b1) : cur_raw;
    assign cur_over = cur_valid && (cur_mag > cur_thresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_low_q <= 1'b0;
        end else if (cur_valid) begin
            cur_low_q <= (cur_mag < cur_thresh);
        end
    end

    // ---------------- idle-bus qualification ----------------
    logic [QW-1:0] qual_q;
    logic          bus_idle;

    assign bus_idle = (qual_q == QUAL_FULL);

    always_ff @(posedge clk) begin
        if (rst || bus_high) begin
            qual_q <= '0;
        end else if (ms_tick && !bus_idle) begin
            qual_q <= qual_q + 1'b1;
        end
    end

    // ---------------- mode state machine ----------------
    pmode_t mode_q;
    pmode_t mode_d;
    logic   may_enter;
    logic   must_leave;

    assign may_enter  = cur_low_q && bus_idle && !bus_high && !cfg_sleep_dis && !cur_over;
    assign must_leave = cfg_sleep_dis || bus_rise || bus_high || cur_over;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_FULL:  if (may_enter)  mode_d = MODE_SLEEP;
            MODE_SLEEP: if (must_leave) mode_d = MODE_FULL;
            default:    mode_d = MODE_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FULL;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign sleep_mode = (mode_q == MODE_SLEEP);

    // ---------------- wake timers ----------------
    wake_req_t wreq;
    logic      vt_hit;
    logic      ic_hit;

    bsc_wake_timer #(.TW(TW)) u_vt_timer (
        .clk    (clk),
        .rst    (rst),
        .active (sleep_mode),
        .tick   (ms_tick),
        .period (sleep_period),
        .req    (vt_hit)
    );

    bsc_wake_timer #(.TW(TW)) u_ic_timer (
        .clk    (clk),
        .rst    (rst),
        .active (sleep_mode),
        .tick   (ms_tick),
        .period (icheck_period),
        .req    (ic_hit)
    );

    always_comb begin
        wreq.vt  = vt_hit;
        wreq.sd  = vt_hit;
        wreq.cur = ic_hit;
    end

    assign vt_meas_req  = wreq.vt;
    assign self_dis_req = wreq.sd;
    assign cur_meas_req = wreq.cur;

    // ---------------- assertions ----------------
    AST_ENTRY_NEEDS_LOW_CUR: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_mode) |-> $past(cur_low_q)); // R1

    AST_ENTRY_NEEDS_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_mode) |-> $past(bus_idle)); // R1

    AST_IDLE_CLEARED_BY_HIGH: assert property (@(posedge clk) disable iff (rst)
        bus_high |=> !bus_idle); // R2

    AST_OVER_CUR_WAKES: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode && cur_over) |=> !sleep_mode); // R6

    AST_BUS_HIGH_WAKES: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode && bus_high) |=> !sleep_mode); // R7

    AST_DISABLE_HOLDS_FULL: assert property (@(posedge clk) disable iff (rst)
        cfg_sleep_dis |=> !sleep_mode); // R8

    AST_TIMERS_START_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_mode) |-> !$past(vt_meas_req) && !$past(cur_meas_req)); // R5

endmodule

// File: tb/sim_bat_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_bat_sleep_ctrl;

    localparam int CW   = 12;
    localparam int TWB  = 8;
    localparam int DIV  = 4;
    localparam int QMS  = 5;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [CW-1:0] cur_sample = '0;
    logic                 cur_valid = 1'b0;
    logic                 bus_clk_line = 1'b1;
    logic                 bus_dat_line = 1'b1;
    logic                 cfg_sleep_dis = 1'b0;
    logic [CW-1:0]        cur_thresh = 12'd50;
    logic [TWB-1:0]       sleep_period = 8'd3;
    logic [TWB-1:0]       icheck_period = 8'd2;
    logic                 sleep_mode, vt_meas_req, self_dis_req, cur_meas_req;

    bat_sleep_ctrl #(.CUR_W(CW), .TW(TWB), .TICK_DIV(DIV), .QUAL_MS(QMS)) u0 (
        .clk(clk), .rst(rst), .cur_sample(cur_sample), .cur_valid(cur_valid),
        .bus_clk_line(bus_clk_line), .bus_dat_line(bus_dat_line),
        .cfg_sleep_dis(cfg_sleep_dis), .cur_thresh(cur_thresh),
        .sleep_period(sleep_period), .icheck_period(icheck_period),
        .sleep_mode(sleep_mode), .vt_meas_req(vt_meas_req),
        .self_dis_req(self_dis_req), .cur_meas_req(cur_meas_req)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string tag      = "R10";
    int    cnt_vt   = 0;
    int    cnt_cur  = 0;
    int    cnt_both = 0;

    // ---------------- behavioural reference ----------------
    int m_s1c, m_s2c, m_s3c, m_s1d, m_s2d, m_s3d;
    int m_pc, m_tick, m_q, m_low, m_sleep, m_c1, m_c2;

    function automatic int mag_of(logic signed [CW-1:0] v);
        int x;
        x = int'(v);
        return (x < 0) ? -x : x;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1c = 0; m_s2c = 0; m_s3c = 0; m_s1d = 0; m_s2d = 0; m_s3d = 0;
            m_pc = 0; m_tick = 0; m_q = 0; m_low = 0; m_sleep = 0; m_c1 = 0; m_c2 = 0;
        end else begin
            int hi, rs, over, mg, th, sp, ip, f1, f2, nxt, ntick;
            mg   = mag_of(cur_sample);
            th   = int'(cur_thresh);
            sp   = int'(sleep_period);
            ip   = int'(icheck_period);
            hi   = m_s2c | m_s2d;
            rs   = (m_s2c & ~m_s3c & 1) | (m_s2d & ~m_s3d & 1);
            over = (cur_valid && mg > th) ? 1 : 0;
            f1   = (m_sleep && m_tick && sp != 0 && m_c1 == sp - 1) ? 1 : 0;
            f2   = (m_sleep && m_tick && ip != 0 && m_c2 == ip - 1) ? 1 : 0;
            if (!m_sleep)
                nxt = (m_low && m_q == QMS && !hi && !cfg_sleep_dis && !over) ? 1 : 0;
            else
                nxt = (cfg_sleep_dis || rs || hi || over) ? 0 : 1;
            if (!m_sleep) m_c1 = 0; else if (m_tick) m_c1 = f1 ? 0 : (m_c1 + 1) % 256;
            if (!m_sleep) m_c2 = 0; else if (m_tick) m_c2 = f2 ? 0 : (m_c2 + 1) % 256;
            if (hi) m_q = 0; else if (m_tick && m_q < QMS) m_q = m_q + 1;
            if (cur_valid) m_low = (mg < th) ? 1 : 0;
            ntick  = (m_pc == DIV - 1) ? 1 : 0;
            m_pc   = ntick ? 0 : m_pc + 1;
            m_tick = ntick;
            m_s3c = m_s2c; m_s2c = m_s1c; m_s1c = int'(bus_clk_line);
            m_s3d = m_s2d; m_s2d = m_s1d; m_s1d = int'(bus_dat_line);
            m_sleep = nxt;
        end
    end

    task automatic check(string t, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            int sp, ip, e_vt, e_cur;
            sp    = int'(sleep_period);
            ip    = int'(icheck_period);
            e_vt  = (m_sleep && m_tick && sp != 0 && m_c1 == sp - 1) ? 1 : 0;
            e_cur = (m_sleep && m_tick && ip != 0 && m_c2 == ip - 1) ? 1 : 0;
            check({tag, " mode"}, int'(sleep_mode), m_sleep);
            check({tag, " vt_req"}, int'(vt_meas_req), e_vt);
            check({tag, " sd_req"}, int'(self_dis_req), e_vt);
            check({tag, " cur_req"}, int'(cur_meas_req), e_cur);
            cnt_vt   += int'(vt_meas_req);
            cnt_cur  += int'(cur_meas_req);
            cnt_both += int'(vt_meas_req && cur_meas_req);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic sample(int v);
        cur_sample = CW'(v);
        cur_valid  = 1'b1;
        cyc(1);
        cur_valid  = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(4);
        // R10: reset state
        check("R10 reset mode", int'(sleep_mode), 0);
        check("R10 reset reqs", int'(vt_meas_req | self_dis_req | cur_meas_req), 0);
        rst = 1'b0;
        cyc(1);

        // R1: low current plus idle bus enters sleep
        tag = "R1";
        sample(10);
        bus_clk_line = 1'b0; bus_dat_line = 1'b0;
        cyc(40);
        check("R1 entered sleep", int'(sleep_mode), 1);

        // R3 / R4: free-running timers in sleep
        tag = "R3";
        cnt_vt = 0; cnt_cur = 0;
        cyc(60);
        check("R3 vt pulses seen", int'(cnt_vt > 0), 1);
        check("R4 cur pulses seen", int'(cnt_cur > cnt_vt), 1);

        // R6: equal magnitude stays, larger magnitude wakes
        tag = "R6";
        sample(50);
        cyc(5);
        check("R6 equal keeps sleep", int'(sleep_mode), 1);
        sample(-51);
        check("R6 negative over wakes", int'(sleep_mode), 0);

        // R5: common multiple of periods, fresh timers
        tag = "R5";
        sleep_period = 8'd6; icheck_period = 8'd3;
        sample(-20);
        cyc(40);
        check("R5 re-entered", int'(sleep_mode), 1);
        cnt_both = 0;
        cyc(60);
        check("R5 coincident requests", int'(cnt_both > 0), 1);

        // R7: data line pulse wakes
        tag = "R7";
        bus_dat_line = 1'b1; cyc(1); bus_dat_line = 1'b0;
        cyc(4);
        check("R7 data edge wakes", int'(sleep_mode), 0);

        // R2: glitch restarts qualification
        tag = "R2";
        bus_clk_line = 1'b1; cyc(5); bus_clk_line = 1'b0;
        cyc(12);
        bus_clk_line = 1'b1; cyc(1); bus_clk_line = 1'b0;
        cyc(16);
        check("R2 glitch restarted window", int'(sleep_mode), 0);
        cyc(30);
        check("R2 qualified later", int'(sleep_mode), 1);

        // R8: disable bit forces and holds full mode
        tag = "R8";
        cfg_sleep_dis = 1'b1;
        cyc(1);
        check("R8 forced out", int'(sleep_mode), 0);
        cyc(40);
        check("R8 never enters", int'(sleep_mode), 0);
        cfg_sleep_dis = 1'b0;
        cyc(40);
        check("R8 enters when cleared", int'(sleep_mode), 1);

        // R3: period 0 silences the voltage/temperature timer
        tag = "R3";
        sleep_period = 8'd0;
        cnt_vt = 0; cnt_cur = 0;
        cyc(80);
        check("R3 zero period no vt", cnt_vt, 0);
        check("R4 cur timer independent", int'(cnt_cur > 0), 1);

        // R9: synchronizer latency on a clock line rise
        tag = "R9";
        sleep_period = 8'd3;
        bus_clk_line = 1'b1;
        cyc(2);
        check("R9 still asleep after two edges", int'(sleep_mode), 1);
        cyc(1);
        check("R9 awake after third edge", int'(sleep_mode), 0);
        bus_clk_line = 1'b0;
        cyc(10);

        finish_run();
    end

endmodule